// File: doc/BRIEF.md
# Video Raster Timing Generator

This block keeps the beam position of a video output. Every cycle in which the master-clock enable is high, it converts one master cycle into video ticks at a rate of 11/7, carrying the leftover fraction into the next step. The tick counter wraps at the line length and advances the scanline counter. The scanline counter wraps at the frame length, and that wrap starts a new frame. Line and frame lengths depend on the region select. In interlaced operation each new frame starts on line 0 or line 1, depending on the field flag, which toggles at every frame.

Programmable horizontal and vertical display windows set the blanking levels. The block raises a one-cycle interrupt pulse when vertical blanking begins and a one-cycle tick pulse each time horizontal blanking begins, for an external counter. It also drives a gate level that follows vertical blanking and a flag that marks even lines. From the resolution bits and the window registers it derives the dot-clock divider and the visible width and height, without using a clock cycle.

Top module: `crtc_timing_gen`

## Requirements
- R1: While rst_n is low the tick, line and field outputs are 0, hblank and vblank are 1, and vblank_irq and hblank_tick are 0.
- R2: Each cycle with mclk_en high adds floor((11+r)/7) to the tick count and keeps (11+r) mod 7 as the new remainder r, which starts at 0. A cycle with mclk_en low changes no counter.
- R3: When the tick count would reach or pass the line total, the line total is subtracted from it and the line count increments. The totals are 3406 ticks by 314 lines with pal_sel=1, and 3413 ticks by 263 lines with pal_sel=0. Both are parameters.
- R4: When the line count would reach the frame total with interlace_en=0, the line restarts at 0 and field_odd is cleared.
- R5: When the line count would reach the frame total with interlace_en=1, field_odd toggles. The line restarts at 1 if the new field is 0 and at 0 if it is 1.
- R6: hrange[11:0] is the horizontal start and hrange[23:12] the horizontal end. vrange[9:0] is the vertical start and vrange[19:9+1] the vertical end. Each bound is first clamped to its total. hblank is 1 when tick < start or tick >= end. vblank follows the same rule on the line count. Both levels are updated on every enabled step.
- R7: vblank_irq is a one-cycle pulse on the step where vblank goes from 0 to 1. timer_gate always equals vblank.
- R8: hblank_tick is a one-cycle pulse on the step where hblank goes from 0 to 1.
- R9: even_line equals the inverse of field_odd when tall_mode and interlace_en are both 1. Otherwise it equals bit 0 of the line count.
- R10: dot_div is looked up with the index {hres_hi, hres_lo}: 0 gives 10, 1 gives 8, 2 gives 5, 3 gives 4, and 4 to 7 give 7. vis_width is (X end − X start)/dot_div with integer division, and is at least 1. It is 1 when the end is not above the start.
- R11: vis_height is (Y end − Y start), or 0 when the end is not above the start. It is doubled when tall_mode and interlace_en are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en | input | 1 | One master cycle elapsed |
| pal_sel | input | 1 | 1 selects the 50 Hz totals |
| interlace_en | input | 1 | Interlaced fields on |
| tall_mode | input | 1 | Double-height line mode |
| hres_lo | input | 2 | Low horizontal resolution bits |
| hres_hi | input | 1 | High horizontal resolution bit |
| hrange | input | 24 | Horizontal window: start [11:0], end [23:12] |
| vrange | input | 20 | Vertical window: start [9:0], end [19:10] |
| tick_count | output | 12 | Video tick within the line |
| line_count | output | 9 | Current scanline |
| field_odd | output | 1 | Interlace field flag |
| hblank | output | 1 | Horizontal blanking level |
| vblank | output | 1 | Vertical blanking level |
| vblank_irq | output | 1 | Pulse on vblank entry |
| hblank_tick | output | 1 | Pulse on hblank entry |
| timer_gate | output | 1 | Gate level for a timer, follows vblank |
| even_line | output | 1 | Even-line flag |
| dot_div | output | 4 | Dot-clock divider |
| vis_width | output | 12 | Visible width in dots |
| vis_height | output | 11 | Visible height in lines |

## Verification
Counters, blanking levels and pulses are registered. They take their new value at the same rising edge that samples mclk_en, so they are due one edge after the enable is presented. The pulses last exactly one cycle after that edge. even_line, dot_div, vis_width and vis_height are combinational from the current inputs and counters, so they are due in the same cycle. The bench drives inputs on the falling edge and updates a behavioural model on each rising edge. It then compares every output against the model on the next falling edge, so both the registered results and the combinational results are sampled at the cycle in which they are due.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int DIV_W = 4;

  // Dot-clock divider chosen by the three horizontal resolution bits
  function automatic logic [DIV_W-1:0] div_lookup(input logic [2:0] idx);
    logic [DIV_W-1:0] d;
    case (idx)
      3'd0:    d = DIV_W'(10);
      3'd1:    d = DIV_W'(8);
      3'd2:    d = DIV_W'(5);
      3'd3:    d = DIV_W'(4);
      default: d = DIV_W'(7);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/crtc_rate_conv.sv
module crtc_rate_conv #(
  parameter int MUL    = 11,
  parameter int DIV    = 7,
  parameter int FRAC_W = $clog2(DIV),
  parameter int ADD_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ADD_W-1:0] add
);
  localparam int ACC_W = $clog2(MUL + DIV) + 1;

  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [ACC_W-1:0]  acc;

  always_comb begin
    acc    = ACC_W'(frac_q) + ACC_W'(MUL);
    add    = ADD_W'(acc / ACC_W'(DIV));
    frac_d = frac_q;
    if (step) frac_d = FRAC_W'(acc % ACC_W'(DIV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end

  // R2
  frac_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frac_q) < DIV);
endmodule

// File: rtl/crtc_counters.sv
module crtc_counters #(
  parameter int TICK_W = 12,
  parameter int LINE_W = 9,
  parameter int ADD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [ADD_W-1:0]  add,
  input  logic [TICK_W-1:0] htot,
  input  logic [LINE_W-1:0] vtot,
  input  logic              lace,
  output logic [TICK_W-1:0] tick_q,
  output logic [LINE_W-1:0] line_q,
  output logic              field_q,
  output logic [TICK_W-1:0] tick_d,
  output logic [LINE_W-1:0] line_d
);
  localparam int SUM_W = TICK_W + 1;
  localparam int LN_W  = LINE_W + 1;

  logic [SUM_W-1:0] sum;
  logic [LN_W-1:0]  line_inc;
  logic             field_d;

  always_comb begin
    sum      = {1'b0, tick_q} + SUM_W'(add);
    line_inc = {1'b0, line_q} + LN_W'(1);
    tick_d   = tick_q;
    line_d   = line_q;
    field_d  = field_q;
    if (step) begin
      if (sum >= {1'b0, htot}) begin
        tick_d = TICK_W'(sum - {1'b0, htot});
        if (line_inc >= {1'b0, vtot}) begin
          if (lace) begin
            field_d = ~field_q;
            line_d  = field_q ? LINE_W'(1) : '0;
          end else begin
            field_d = 1'b0;
            line_d  = '0;
          end
        end else begin
          line_d = LINE_W'(line_inc);
        end
      end else begin
        tick_d = TICK_W'(sum);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
    end else begin
      tick_q  <= tick_d;
      line_q  <= line_d;
      field_q <= field_d;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(tick_q) && $stable(line_q) && $stable(field_q)));
  // R2
  tick_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (tick_q != $past(tick_q)));
  // R5
  field_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q != $past(field_q)) |-> (line_q <= LINE_W'(1)));
endmodule

// File: rtl/crtc_blank.sv
module crtc_blank #(
  parameter int TICK_W = 12,
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [TICK_W-1:0] tick_d,
  input  logic [LINE_W-1:0] line_d,
  input  logic [TICK_W-1:0] hstart,
  input  logic [TICK_W-1:0] hend,
  input  logic [LINE_W-1:0] vstart,
  input  logic [LINE_W-1:0] vend,
  output logic              hblank,
  output logic              vblank,
  output logic              irq,
  output logic              htick
);
  logic hb_d, vb_d, irq_d, htick_d;

  always_comb begin
    hb_d    = hblank;
    vb_d    = vblank;
    irq_d   = 1'b0;
    htick_d = 1'b0;
    if (step) begin
      hb_d    = (tick_d < hstart) || (tick_d >= hend);
      vb_d    = (line_d < vstart) || (line_d >= vend);
      irq_d   = vb_d & ~vblank;
      htick_d = hb_d & ~hblank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hblank <= 1'b1;
      vblank <= 1'b1;
      irq    <= 1'b0;
      htick  <= 1'b0;
    end else begin
      hblank <= hb_d;
      vblank <= vb_d;
      irq    <= irq_d;
      htick  <= htick_d;
    end
  end

  // R7
  irq_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vblank && !$past(vblank)));
  // R8
  htick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htick |-> (hblank && !$past(hblank)));
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/crtc_geom.sv
module crtc_geom
  import crtc_pkg::*;
#(
  parameter int TICK_W   = 12,
  parameter int LINE_W   = 9,
  parameter int VR_W     = 10,
  parameter int P_HTOTAL = 3406,
  parameter int P_VTOTAL = 314,
  parameter int N_HTOTAL = 3413,
  parameter int N_VTOTAL = 263
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pal_sel,
  input  logic                tall,
  input  logic [2:0]          hres_idx,
  input  logic [2*TICK_W-1:0] hrange,
  input  logic [2*VR_W-1:0]   vrange,
  output logic [TICK_W-1:0]   htot,
  output logic [LINE_W-1:0]   vtot,
  output logic [TICK_W-1:0]   hstart,
  output logic [TICK_W-1:0]   hend,
  output logic [LINE_W-1:0]   vstart,
  output logic [LINE_W-1:0]   vend,
  output logic [DIV_W-1:0]    dot_div,
  output logic [TICK_W-1:0]   width,
  output logic [VR_W:0]       height
);
  localparam int VW = (VR_W > LINE_W) ? VR_W : LINE_W;

  logic [TICK_W-1:0] x_lo, x_hi, diff, quot;
  logic [VR_W-1:0]   y_lo, y_hi;
  logic [VW-1:0]     vt_w, ylo_w, yhi_w;

  always_comb begin
    x_lo  = hrange[TICK_W-1:0];
    x_hi  = hrange[2*TICK_W-1:TICK_W];
    y_lo  = vrange[VR_W-1:0];
    y_hi  = vrange[2*VR_W-1:VR_W];
    htot  = pal_sel ? TICK_W'(P_HTOTAL) : TICK_W'(N_HTOTAL);
    vtot  = pal_sel ? LINE_W'(P_VTOTAL) : LINE_W'(N_VTOTAL);
    vt_w  = VW'(vtot);
    ylo_w = VW'(y_lo);
    yhi_w = VW'(y_hi);
    hstart = (x_lo < htot) ? x_lo : htot;
    hend   = (x_hi < htot) ? x_hi : htot;
    vstart = LINE_W'((ylo_w < vt_w) ? ylo_w : vt_w);
    vend   = LINE_W'((yhi_w < vt_w) ? yhi_w : vt_w);
    dot_div = div_lookup(hres_idx);
    diff    = x_hi - x_lo;
    quot    = diff / TICK_W'(dot_div);
    width   = ((x_hi <= x_lo) || (quot == '0)) ? TICK_W'(1) : quot;
    height  = (y_hi > y_lo) ? (VR_W+1)'(y_hi - y_lo) : '0;
    if (tall) height = height << 1;
  end

  // R10
  width_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    width != '0);
  // R6
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hend <= htot) && (vend <= vtot));
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int P_HTOTAL = 3406,
  parameter int P_VTOTAL = 314,
  parameter int N_HTOTAL = 3413,
  parameter int N_VTOTAL = 263,
  parameter int RATE_MUL = 11,
  parameter int RATE_DIV = 7,
  parameter int TICK_W   = 12,
  parameter int LINE_W   = 9,
  parameter int VR_W     = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mclk_en,
  input  logic                pal_sel,
  input  logic                interlace_en,
  input  logic                tall_mode,
  input  logic [1:0]          hres_lo,
  input  logic                hres_hi,
  input  logic [2*TICK_W-1:0] hrange,
  input  logic [2*VR_W-1:0]   vrange,
  output logic [TICK_W-1:0]   tick_count,
  output logic [LINE_W-1:0]   line_count,
  output logic                field_odd,
  output logic                hblank,
  output logic                vblank,
  output logic                vblank_irq,
  output logic                hblank_tick,
  output logic                timer_gate,
  output logic                even_line,
  output logic [DIV_W-1:0]    dot_div,
  output logic [TICK_W-1:0]   vis_width,
  output logic [VR_W:0]       vis_height
);
  localparam int FRAC_W = $clog2(RATE_DIV);
  localparam int ADD_W  = $clog2((RATE_MUL + RATE_DIV - 1) / RATE_DIV + 1);

  logic [ADD_W-1:0]  add;
  logic [TICK_W-1:0] htot, hstart, hend, tick_d;
  logic [LINE_W-1:0] vtot, vstart, vend, line_d;
  logic              tall_lace;

  assign tall_lace = tall_mode & interlace_en;

  crtc_geom #(
    .TICK_W(TICK_W), .LINE_W(LINE_W), .VR_W(VR_W),
    .P_HTOTAL(P_HTOTAL), .P_VTOTAL(P_VTOTAL),
    .N_HTOTAL(N_HTOTAL), .N_VTOTAL(N_VTOTAL)
  ) u_geom (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .tall(tall_lace),
    .hres_idx({hres_hi, hres_lo}), .hrange(hrange), .vrange(vrange),
    .htot(htot), .vtot(vtot), .hstart(hstart), .hend(hend),
    .vstart(vstart), .vend(vend), .dot_div(dot_div),
    .width(vis_width), .height(vis_height)
  );

  crtc_rate_conv #(
    .MUL(RATE_MUL), .DIV(RATE_DIV), .FRAC_W(FRAC_W), .ADD_W(ADD_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .step(mclk_en), .add(add)
  );

  crtc_counters #(
    .TICK_W(TICK_W), .LINE_W(LINE_W), .ADD_W(ADD_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(mclk_en), .add(add),
    .htot(htot), .vtot(vtot), .lace(interlace_en),
    .tick_q(tick_count), .line_q(line_count), .field_q(field_odd),
    .tick_d(tick_d), .line_d(line_d)
  );

  crtc_blank #(
    .TICK_W(TICK_W), .LINE_W(LINE_W)
  ) u_blank (
    .clk(clk), .rst_n(rst_n), .step(mclk_en),
    .tick_d(tick_d), .line_d(line_d),
    .hstart(hstart), .hend(hend), .vstart(vstart), .vend(vend),
    .hblank(hblank), .vblank(vblank), .irq(vblank_irq), .htick(hblank_tick)
  );

  assign timer_gate = vblank;
  assign even_line  = tall_lace ? ~field_odd : line_count[0];
endmodule

// File: tb/crtc_timing_gen_bench.sv
module crtc_timing_gen_bench;
  localparam int PH = 40, PV = 12, NH = 46, NV = 10;

  logic        clk = 1'b0;
  logic        rst_n, mclk_en, pal_sel, interlace_en, tall_mode, hres_hi;
  logic [1:0]  hres_lo;
  logic [23:0] hrange;
  logic [19:0] vrange;
  logic [11:0] tick_count, vis_width;
  logic [8:0]  line_count;
  logic        field_odd, hblank, vblank, vblank_irq, hblank_tick, timer_gate, even_line;
  logic [3:0]  dot_div;
  logic [10:0] vis_height;

  crtc_timing_gen #(
    .P_HTOTAL(PH), .P_VTOTAL(PV), .N_HTOTAL(NH), .N_VTOTAL(NV)
  ) u_crtc_timing_gen (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .pal_sel(pal_sel),
    .interlace_en(interlace_en), .tall_mode(tall_mode), .hres_lo(hres_lo),
    .hres_hi(hres_hi), .hrange(hrange), .vrange(vrange),
    .tick_count(tick_count), .line_count(line_count), .field_odd(field_odd),
    .hblank(hblank), .vblank(vblank), .vblank_irq(vblank_irq),
    .hblank_tick(hblank_tick), .timer_gate(timer_gate), .even_line(even_line),
    .dot_div(dot_div), .vis_width(vis_width), .vis_height(vis_height)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  int m_tick, m_line, m_frac, m_field, m_hb, m_vb, m_irq, m_htick;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_line = 0; m_frac = 0; m_field = 0;
      m_hb = 1; m_vb = 1; m_irq = 0; m_htick = 0;
    end else if (mclk_en) begin
      int ht, vt, t, l, acc, nhb, nvb;
      ht  = pal_sel ? PH : NH;
      vt  = pal_sel ? PV : NV;
      acc = 11 + m_frac;
      m_frac = acc % 7;
      t = m_tick + acc / 7;
      l = m_line;
      if (t >= ht) begin
        t = t - ht;
        l = m_line + 1;
        if (l >= vt) begin
          if (interlace_en) begin
            m_field = 1 - m_field;
            l = (m_field == 1) ? 0 : 1;
          end else begin
            m_field = 0;
            l = 0;
          end
        end
      end
      m_tick = t; m_line = l;
      nhb = (t < imin(int'(hrange[11:0]), ht) || t >= imin(int'(hrange[23:12]), ht)) ? 1 : 0;
      nvb = (l < imin(int'(vrange[9:0]), vt) || l >= imin(int'(vrange[19:10]), vt)) ? 1 : 0;
      m_htick = (nhb == 1 && m_hb == 0) ? 1 : 0;
      m_irq   = (nvb == 1 && m_vb == 0) ? 1 : 0;
      m_hb = nhb; m_vb = nvb;
    end else begin
      m_irq = 0; m_htick = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int div, x1, x2, y1, y2, w, h, tl;
      chk("R2", "tick_count", int'(tick_count), m_tick);
      chk("R3", "line_count", int'(line_count), m_line);
      chk("R5", "field_odd", int'(field_odd), m_field);
      chk("R6", "hblank", int'(hblank), m_hb);
      chk("R6", "vblank", int'(vblank), m_vb);
      chk("R7", "vblank_irq", int'(vblank_irq), m_irq);
      chk("R7", "timer_gate", int'(timer_gate), m_vb);
      chk("R8", "hblank_tick", int'(hblank_tick), m_htick);
      tl = (tall_mode && interlace_en) ? 1 : 0;
      chk("R9", "even_line", int'(even_line), (tl == 1) ? 1 - m_field : (m_line % 2));
      case ({hres_hi, hres_lo})
        3'd0: div = 10; 3'd1: div = 8; 3'd2: div = 5; 3'd3: div = 4;
        default: div = 7;
      endcase
      x1 = int'(hrange[11:0]); x2 = int'(hrange[23:12]);
      y1 = int'(vrange[9:0]);  y2 = int'(vrange[19:10]);
      w  = (x2 > x1) ? (x2 - x1) / div : 0;
      if (w < 1) w = 1;
      h  = (y2 > y1) ? (y2 - y1) : 0;
      if (tl == 1) h = h * 2;
      chk("R10", "dot_div", int'(dot_div), div);
      chk("R10", "vis_width", int'(vis_width), w);
      chk("R11", "vis_height", int'(vis_height), h);
    end
  end

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mclk_en = (($urandom % 100) < pct);
      if (i % 97 == 0) {hres_hi, hres_lo} = 3'($urandom);
    end
  endtask

  initial begin
    rst_n = 1'b0; mclk_en = 1'b0; pal_sel = 1'b0; interlace_en = 1'b0;
    tall_mode = 1'b0; hres_hi = 1'b0; hres_lo = 2'd0;
    hrange = {12'd30, 12'd5};
    vrange = {10'd8, 10'd2};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "tick reset", int'(tick_count), 0);
    chk("R1", "line reset", int'(line_count), 0);
    chk("R1", "hblank reset", int'(hblank), 1);
    chk("R1", "vblank reset", int'(vblank), 1);
    chk("R1", "pulses reset", int'(vblank_irq) + int'(hblank_tick), 0);
    cmp_on = 1;
    rst_n = 1'b1;
    run(1500, 100);          // R2 R3 R4 full rate, 60 Hz totals
    run(1500, 50);           // R2 sparse enables, R10 divider sweep
    interlace_en = 1'b1;
    run(3000, 80);           // R5 field toggling
    tall_mode = 1'b1;
    run(2000, 90);           // R9 R11 tall interlaced
    pal_sel = 1'b1;
    run(3000, 85);           // R3 50 Hz totals
    hrange = {12'd100, 12'd7};
    vrange = {10'd3, 10'd9};
    run(1500, 90);           // R6 clamp and inverted window
    hrange = {12'd4, 12'd20};
    vrange = {10'd900, 10'd0};
    run(1500, 90);           // R10 R11 end below start, clamp vertical
    mclk_en = 1'b0;
    run(200, 0);             // R2 hold without enable
    interlace_en = 1'b0; tall_mode = 1'b0; pal_sel = 1'b0;
    hrange = {12'd40, 12'd2};
    vrange = {10'd7, 10'd1};
    run(1500, 100);          // R4 field cleared at wrap
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule